// File: doc/BRIEF.md
# Spike Area Feature Extractor

This block turns one detected neural spike of `SPIKE_N` signed 10-bit samples into a two-element feature vector. It locates the global minimum of the spike and uses its position to cut the waveform into a leading part and a trailing part. Each feature is the sum of one part's samples divided by the spike's peak-to-peak range (global maximum minus global minimum). The quotient carries `FRAC_W` fractional bits and is truncated toward zero.

Samples arrive `LANES` per clock. Inside each beat, a tree of leaf and merge nodes finds the minimum, its position, the maximum, the beat's total and the sum in front of the minimum. The beat result is then folded into a running result. Because the minimum search and the area sums run in the same pass, the last beat leaves the block with everything the division needs. A single bit-serial divider pair at the root then produces both quotients. The upstream spike buffer frames each spike with a start flag on its first beat. It must hold its data while the block reports that it is not ready, which is the case during the division.

Top module: `spf_feature_extract`

## Requirements
- R1: After reset, `inReady` is 1, `outValid` is 0, and `outFeatPre`, `outFeatPost` and `outMinIdx` are 0.
- R2: `outMinIdx` is the sample index of the smallest sample of the spike. When several samples share the minimum value, the lowest index wins, both inside a beat and across beats.
- R3: `outFeatPre` is trunc(A*2^FRAC_W/(max-min)), where A is the sum of the samples with index below `outMinIdx`. `outFeatPost` is the same with A the sum of the samples with index at or above `outMinIdx`. Both are two's complement, and truncation is toward zero (FRAC_W = 8).
- R4: When every sample of the spike is equal (max equals min), both features are 0.
- R5: A beat carries `LANES` samples. Lane j occupies `inData[j*10 +: 10]` and holds sample index beat*LANES + j. A spike is complete after `SPIKE_N/LANES` accepted beats.
- R6: `outValid` is high for exactly one cycle. It rises `DIV_CYC+1` rising edges after the edge that accepts the last beat of a spike, where DIV_CYC = AREA_W + FRAC_W = 23 for the defaults.
- R7: `inReady` is 0 from the edge that accepts a last beat until the cycle in which `outValid` is high. Beats offered while `inReady` is 0 have no effect.
- R8: A beat accepted with `inStart` = 1 begins a new spike at index 0 and discards any partly received spike.
- R9: A beat with `inStart` = 0 that arrives while no spike is in progress is ignored.
- R10: `outFeatPre`, `outFeatPost` and `outMinIdx` change only in the cycle in which `outValid` is high. Otherwise they hold their last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A beat is offered on `inData` |
| inStart | input | 1 | The offered beat is the first beat of a spike |
| inData | input | LANES*SAMPLE_W (40) | Samples of the beat, lane 0 in the low bits |
| inReady | output | 1 | The block takes the offered beat at this edge |
| outValid | output | 1 | One-cycle pulse: new feature vector |
| outFeatPre | output | FEAT_W (24) | Normalised area in front of the minimum |
| outFeatPost | output | FEAT_W (24) | Normalised area from the minimum on |
| outMinIdx | output | IDX_W (5) | Index of the global minimum |

## Verification
On every cycle, the assertions check the timing of the handshake. They check that the result pulse lasts one cycle, that it arrives exactly after the busy window, that the busy window never runs longer than the division, and that the outputs hold between pulses. The values themselves come only from the bench's scenarios, checked against a behavioural model. These scenarios cover the minimum at either end of the spike and ties within and across beats. They also cover flat spikes, full-scale and all-negative spikes, restarts in mid-spike, stray beats while idle or busy, gaps between beats, and random spikes.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;
  parameter int SAMPLE_W = 10;
  parameter int SPIKE_N  = 32;
  parameter int LANES    = 4;
  parameter int FRAC_W   = 8;

  localparam int IDX_W   = $clog2(SPIKE_N);
  localparam int BEATS   = SPIKE_N / LANES;
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int AREA_W  = SAMPLE_W + IDX_W;
  localparam int RANGE_W = SAMPLE_W + 1;
  localparam int DVD_W   = AREA_W + FRAC_W;
  localparam int FEAT_W  = DVD_W + 1;
  localparam int DIV_CYC = DVD_W;
  localparam int LATENCY = DIV_CYC + 1;
  localparam int CNT_W   = $clog2(DIV_CYC + 1);

  // Partial result of a run of consecutive samples
  typedef struct packed {
    logic signed [SAMPLE_W-1:0] minVal;
    logic signed [SAMPLE_W-1:0] maxVal;
    logic [IDX_W-1:0]           minIdx;
    logic signed [AREA_W-1:0]   total;
    logic signed [AREA_W-1:0]   pre;
  } segSum_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic beatTake;
    logic beatFirst;
    logic loadDiv;
    logic divStep;
    logic finish;
  } ctlStrobe_t;

  function automatic segSum_t leafSeg(logic signed [SAMPLE_W-1:0] x, logic [IDX_W-1:0] idx);
    segSum_t r;
    r.minVal = x;
    r.maxVal = x;
    r.minIdx = idx;
    r.total  = AREA_W'(x);
    r.pre    = '0;
    return r;
  endfunction

  // early precedes late in sample order; ties keep the earlier minimum
  function automatic segSum_t mergeSeg(segSum_t early, segSum_t late);
    segSum_t r;
    r.total  = early.total + late.total;
    r.maxVal = (late.maxVal > early.maxVal) ? late.maxVal : early.maxVal;
    if (late.minVal < early.minVal) begin
      r.minVal = late.minVal;
      r.minIdx = late.minIdx;
      r.pre    = early.total + late.pre;
    end else begin
      r.minVal = early.minVal;
      r.minIdx = early.minIdx;
      r.pre    = early.pre;
    end
    return r;
  endfunction
endpackage

// File: rtl/spf_seg_tree.sv
`timescale 1ns/1ps
module spf_seg_tree
  import spf_pkg::*;
(
  input  logic [LANES*SAMPLE_W-1:0] beatData,
  input  logic [IDX_W-1:0]          baseIdx,
  output segSum_t                   beatSum
);
  // heap order: node 0 is the root, leaves at LANES-1 .. 2*LANES-2
  segSum_t node [2*LANES-1];

  for (genvar j = 0; j < LANES; j++) begin : g_leaf
    assign node[LANES-1+j] = leafSeg($signed(beatData[j*SAMPLE_W +: SAMPLE_W]),
                                     baseIdx + IDX_W'(j));
  end

  for (genvar i = 0; i < LANES-1; i++) begin : g_merge
    assign node[i] = mergeSeg(node[2*i+1], node[2*i+2]);
  end

  assign beatSum = node[0];
endmodule

// File: rtl/spf_divider.sv
`timescale 1ns/1ps
module spf_divider #(
  parameter int DVD_W = 23,
  parameter int DEN_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic [DVD_W-1:0] quotient
);
  logic [DEN_W-1:0] remQ;
  logic [DVD_W-1:0] quoQ;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {remQ, quoQ[DVD_W-1]};
  assign fits  = trial >= {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ <= '0;
      quoQ <= '0;
    end else if (load) begin
      remQ <= '0;
      quoQ <= dividend;
    end else if (step) begin
      remQ <= fits ? DEN_W'(trial - {1'b0, divisor}) : DEN_W'(trial);
      quoQ <= {quoQ[DVD_W-2:0], fits};
    end
  end

  assign quotient = quoQ;
endmodule

// File: rtl/spf_control.sv
`timescale 1ns/1ps
module spf_control
  import spf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inStart,
  output logic              inReady,
  output ctlStrobe_t        ctl,
  output logic [BEAT_W-1:0] beatIdx
);
  typedef enum logic [1:0] {ST_ACC, ST_DIV, ST_FIN} ctlState_t;

  ctlState_t         stateQ;
  logic              inSpikeQ;
  logic [BEAT_W-1:0] beatCntQ;
  logic [CNT_W-1:0]  divCntQ;
  logic              offer, first, take, last;

  assign inReady = (stateQ == ST_ACC);
  assign offer   = inValid && inReady;
  assign first   = offer && inStart;
  assign take    = first || (offer && inSpikeQ);
  assign beatIdx = first ? '0 : beatCntQ;
  assign last    = take && (beatIdx == BEAT_W'(BEATS-1));

  always_comb begin
    ctl.beatTake  = take;
    ctl.beatFirst = first;
    ctl.loadDiv   = last;
    ctl.divStep   = (stateQ == ST_DIV);
    ctl.finish    = (stateQ == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_ACC;
      inSpikeQ <= 1'b0;
      beatCntQ <= '0;
      divCntQ  <= '0;
    end else begin
      case (stateQ)
        ST_ACC: begin
          if (last) begin
            stateQ   <= ST_DIV;
            divCntQ  <= CNT_W'(DIV_CYC);
            inSpikeQ <= 1'b0;
            beatCntQ <= '0;
          end else if (take) begin
            inSpikeQ <= 1'b1;
            beatCntQ <= beatIdx + 1'b1;
          end
        end
        ST_DIV: begin
          divCntQ <= divCntQ - 1'b1;
          if (divCntQ == CNT_W'(1)) stateQ <= ST_FIN;
        end
        default: stateQ <= ST_ACC;
      endcase
    end
  end
endmodule

// File: rtl/spf_datapath.sv
`timescale 1ns/1ps
module spf_datapath
  import spf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobe_t               ctl,
  input  logic [BEAT_W-1:0]        beatIdx,
  input  logic [LANES*SAMPLE_W-1:0] beatData,
  output logic                     outValid,
  output logic signed [FEAT_W-1:0] outFeatPre,
  output logic signed [FEAT_W-1:0] outFeatPost,
  output logic [IDX_W-1:0]         outMinIdx
);
  segSum_t              beatSum, running, accQ;
  logic [IDX_W-1:0]     baseIdx;
  logic [RANGE_W-1:0]   span, denQ;
  logic signed [AREA_W-1:0] area [2];
  logic [DVD_W-1:0]     dvdIn [2];
  logic [DVD_W-1:0]     quot [2];
  logic [1:0]           negQ;
  logic                 zeroQ;

  function automatic logic [AREA_W-1:0] magOf(logic signed [AREA_W-1:0] a);
    return a[AREA_W-1] ? AREA_W'(-a) : AREA_W'(a);
  endfunction

  function automatic logic signed [FEAT_W-1:0] signFix(logic [DVD_W-1:0] q, logic neg, logic zero);
    logic signed [FEAT_W-1:0] m;
    m = FEAT_W'(q);
    if (zero) return '0;
    return neg ? -m : m;
  endfunction

  assign baseIdx = IDX_W'(beatIdx) * IDX_W'(LANES);

  spf_seg_tree u_tree (
    .beatData (beatData),
    .baseIdx  (baseIdx),
    .beatSum  (beatSum)
  );

  assign running = ctl.beatFirst ? beatSum : mergeSeg(accQ, beatSum);
  assign span    = RANGE_W'(running.maxVal) - RANGE_W'(running.minVal);
  assign area[0] = running.pre;
  assign area[1] = running.total - running.pre;

  for (genvar p = 0; p < 2; p++) begin : g_div
    assign dvdIn[p] = {magOf(area[p]), {FRAC_W{1'b0}}};
    spf_divider #(.DVD_W(DVD_W), .DEN_W(RANGE_W)) u_div (
      .clk      (clk),
      .rstN     (rstN),
      .load     (ctl.loadDiv),
      .step     (ctl.divStep),
      .dividend (dvdIn[p]),
      .divisor  (denQ),
      .quotient (quot[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ        <= '0;
      denQ        <= '0;
      negQ        <= '0;
      zeroQ       <= 1'b0;
      outValid    <= 1'b0;
      outFeatPre  <= '0;
      outFeatPost <= '0;
      outMinIdx   <= '0;
    end else begin
      outValid <= ctl.finish;
      if (ctl.beatTake) accQ <= running;
      if (ctl.loadDiv) begin
        denQ  <= span;
        zeroQ <= (span == '0);
        negQ  <= {area[1][AREA_W-1], area[0][AREA_W-1]};
      end
      if (ctl.finish) begin
        outFeatPre  <= signFix(quot[0], negQ[0], zeroQ);
        outFeatPost <= signFix(quot[1], negQ[1], zeroQ);
        outMinIdx   <= accQ.minIdx;
      end
    end
  end
endmodule

// File: rtl/spf_feature_extract.sv
`timescale 1ns/1ps
module spf_feature_extract
  import spf_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic                      inStart,
  input  logic [LANES*SAMPLE_W-1:0] inData,
  output logic                      inReady,
  output logic                      outValid,
  output logic signed [FEAT_W-1:0]  outFeatPre,
  output logic signed [FEAT_W-1:0]  outFeatPost,
  output logic [IDX_W-1:0]          outMinIdx
);
  ctlStrobe_t        ctl;
  logic [BEAT_W-1:0] beatIdx;

  spf_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inStart (inStart),
    .inReady (inReady),
    .ctl     (ctl),
    .beatIdx (beatIdx)
  );

  spf_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .beatIdx     (beatIdx),
    .beatData    (inData),
    .outValid    (outValid),
    .outFeatPre  (outFeatPre),
    .outFeatPost (outFeatPost),
    .outMinIdx   (outMinIdx)
  );
endmodule

// File: rtl/spf_checker.sv
`timescale 1ns/1ps
module spf_checker
  import spf_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     inReady,
  input logic                     outValid,
  input logic signed [FEAT_W-1:0] outFeatPre,
  input logic signed [FEAT_W-1:0] outFeatPost,
  input logic [IDX_W-1:0]         outMinIdx
);
  localparam int BUSY_W = $clog2(LATENCY + 2) + 1;
  logic [BUSY_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else if (inReady) busyCnt <= '0;
    else if (busyCnt != {BUSY_W{1'b1}}) busyCnt <= busyCnt + 1'b1;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R6
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (busyCnt == BUSY_W'(LATENCY))); // R6
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= BUSY_W'(LATENCY)); // R7
  AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inReady); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outFeatPre) && $stable(outFeatPost) && $stable(outMinIdx))); // R10
endmodule

bind spf_feature_extract spf_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inReady     (inReady),
  .outValid    (outValid),
  .outFeatPre  (outFeatPre),
  .outFeatPost (outFeatPost),
  .outMinIdx   (outMinIdx)
);

// File: tb/spf_feature_extract_test.sv
`timescale 1ns/1ps
module spf_feature_extract_test;
  import spf_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inStart = 1'b0;
  logic [LANES*SAMPLE_W-1:0] inData = '0;
  logic inReady, outValid;
  logic signed [FEAT_W-1:0] outFeatPre, outFeatPost;
  logic [IDX_W-1:0] outMinIdx;

  spf_feature_extract uut (.*);

  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  string scen = "reset";
  bit live = 1'b0;

  // behavioural reference model
  int mBuf[$];
  bit mIn = 1'b0;
  int mBusy = 0;
  bit mPulse = 1'b0;
  int pendPre = 0, pendPost = 0, pendIdx = 0;
  bit pendZero = 1'b0;
  int shownPre = 0, shownPost = 0, shownIdx = 0;
  int spk[SPIKE_N];

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s]: actual %0d expected %0d", req, scen, act, exp);
    end
  endtask

  function automatic int featOf(int a, int d);
    if (d == 0) return 0;
    if (a < 0) return -(((-a) * (1 << FRAC_W)) / d);
    return (a * (1 << FRAC_W)) / d;
  endfunction

  function automatic void computeExp();
    int mi = 0, mn = mBuf[0], mx = mBuf[0], pre = 0, post = 0;
    for (int i = 1; i < SPIKE_N; i++) begin
      if (mBuf[i] < mn) begin mn = mBuf[i]; mi = i; end
      if (mBuf[i] > mx) mx = mBuf[i];
    end
    for (int i = 0; i < SPIKE_N; i++) begin
      if (i < mi) pre += mBuf[i]; else post += mBuf[i];
    end
    pendIdx  = mi;
    pendZero = (mx == mn);
    pendPre  = featOf(pre, mx - mn);
    pendPost = featOf(post, mx - mn);
  endfunction

  always @(posedge clk) begin
    mPulse = 1'b0;
    if (!rstN) begin
      mBuf.delete(); mIn = 1'b0; mBusy = 0;
    end else if (mBusy > 0) begin
      mBusy--;
      if (mBusy == 0) begin
        mPulse = 1'b1;
        shownPre = pendPre; shownPost = pendPost; shownIdx = pendIdx;
      end
    end else if (inValid) begin
      if (inStart) begin mBuf.delete(); mIn = 1'b1; end
      if (mIn) begin
        for (int j = 0; j < LANES; j++) mBuf.push_back(int'($signed(inData[j*SAMPLE_W +: SAMPLE_W])));
        if (mBuf.size() == SPIKE_N) begin
          computeExp(); mBusy = LATENCY; mIn = 1'b0; mBuf.delete();
        end
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      check(inReady === (mBusy == 0), "R7 ready", inReady, mBusy == 0);
      check(outValid === mPulse, "R6 valid", outValid, mPulse);
      check(int'(outFeatPre) == shownPre, mPulse ? (pendZero ? "R4 pre" : "R3 pre") : "R10 pre", outFeatPre, shownPre);
      check(int'(outFeatPost) == shownPost, mPulse ? (pendZero ? "R4 post" : "R3 post") : "R10 post", outFeatPost, shownPost);
      check(int'(outMinIdx) == shownIdx, mPulse ? "R2 idx" : "R10 idx", outMinIdx, shownIdx);
    end
  end

  task automatic driveBeat(int b, bit st);
    inValid = 1'b1;
    inStart = st;
    for (int j = 0; j < LANES; j++) inData[j*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(spk[b*LANES+j]);
  endtask

  // R5: beat b carries samples b*LANES .. b*LANES+LANES-1
  task automatic sendRange(int fromB, int toB, int gap);
    for (int b = fromB; b <= toB; b++) begin
      @(negedge clk);
      while (!inReady) begin inValid = 1'b0; inStart = 1'b0; @(negedge clk); end
      driveBeat(b, b == 0);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); inValid = 1'b0; inStart = 1'b0;
      end
    end
    @(negedge clk); inValid = 1'b0; inStart = 1'b0;
  endtask

  task automatic rawBeat(int b, bit st);
    @(negedge clk); driveBeat(b, st);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); inValid = 1'b0; inStart = 1'b0; end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    scen = "R1 reset";
    check(inReady === 1'b1, "R1 ready", inReady, 1);
    check(outValid === 1'b0, "R1 valid", outValid, 0);
    check(outFeatPre == 0 && outFeatPost == 0 && outMinIdx == 0, "R1 outputs", outFeatPre, 0);
    live = 1'b1;

    scen = "R3 R5 minimum inside";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = (i-13)*(i-13)*2 - 300;
    sendRange(0, BEATS-1, 0);

    scen = "R2 minimum at first sample";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = i*10 - 200;
    sendRange(0, BEATS-1, 0);

    scen = "R2 minimum at last sample";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = 200 - i*20;
    sendRange(0, BEATS-1, 0);

    scen = "R2 tie across beats";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = 50;
    spk[6] = -80; spk[21] = -80;
    sendRange(0, BEATS-1, 1);

    scen = "R2 tie inside beat";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = 3*i;
    spk[9] = -90; spk[10] = -90;
    sendRange(0, BEATS-1, 0);

    scen = "R4 flat positive";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = 77;
    sendRange(0, BEATS-1, 0);

    scen = "R4 flat full negative";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = -512;
    sendRange(0, BEATS-1, 0);

    scen = "R3 full scale alternating";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = (i % 2) ? 511 : -512;
    sendRange(0, BEATS-1, 0);

    scen = "R3 all negative truncation";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = -100 - ((i * 37) % 61);
    sendRange(0, BEATS-1, 2);

    scen = "R7 beats while busy ignored";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = 40 - i;
    sendRange(0, BEATS-1, 0);
    for (int i = 0; i < SPIKE_N; i++) spk[i] = -500;
    for (int k = 0; k < 4; k++) rawBeat(k % BEATS, 1'b1);
    idle(LATENCY);
    scen = "R7 clean spike after busy junk";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = (i * 13) % 29 - 14;
    sendRange(0, BEATS-1, 0);

    scen = "R9 stray beats while idle";
    idle(LATENCY + 2);
    for (int i = 0; i < SPIKE_N; i++) spk[i] = -511;
    rawBeat(0, 1'b0);
    rawBeat(3, 1'b0);
    idle(2);
    for (int i = 0; i < SPIKE_N; i++) spk[i] = 100 + i;
    sendRange(0, BEATS-1, 0);

    scen = "R8 restart mid spike";
    for (int i = 0; i < SPIKE_N; i++) spk[i] = -400 + i;
    sendRange(0, 3, 0);
    for (int i = 0; i < SPIKE_N; i++) spk[i] = 60 - ((i * 7) % 23);
    sendRange(0, BEATS-1, 0);

    scen = "R3 random spikes";
    for (int s = 0; s < 24; s++) begin
      for (int i = 0; i < SPIKE_N; i++) spk[i] = int'($urandom_range(1023)) - 512;
      sendRange(0, BEATS-1, s % 3);
    end

    idle(LATENCY + 6);
    live = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule